// File: doc/BRIEF.md
# Instruction Operand Fetch Unit

This unit takes one instruction word in sign-magnitude form (a sign bit followed by five 6-bit bytes) and turns it into the operand the instruction refers to. It latches the word on a start strobe and reads the index register named by the index byte. It forms the effective address as a signed sum of the address field and that register. It then issues one read of a synchronous memory and cuts out the byte range named by the modifier byte. The range is right-aligned in a full word.

The unit is sequential and handles one instruction at a time. A valid instruction finishes with a one-cycle `done` pulse four clock edges after `start` is sampled. An invalid instruction is caught before any memory access and pulses `done` after three edges, with `err` raised. The effective address, opcode, modifier, operand and error flag hold their values from `done` until the next accepted start.

Top module: `operand_fetch_unit`

## Requirements
- R1: After reset, `done`, `err` and `mem_rd_en` are low and `operand` is zero.
- R2: Word layout: bit 30 is the sign (1 = negative) and byte k (k = 1..5) sits in bits [35-6k -: 6]. `opcode` shows byte 5 and `modifier` shows byte 4 of the accepted word. `opcode`, `modifier`, `operand`, `err` and `eff_addr` hold steady after `done` until the next start.
- R3: In the cycle after a start is accepted, `idx_sel` shows the index byte (byte 3) when it is 1..6. The selected register (`idx_val`: bit 12 sign, bits 11:0 magnitude) is added to the address field (sign plus bytes 1 and 2 as a 12-bit magnitude). An index byte of 0 adds nothing.
- R4: The sum is formed in sign-magnitude. Equal signs add magnitudes. Unequal signs subtract, and the result takes the sign of the larger magnitude. A zero result keeps the address field's sign. `eff_addr` is bit 13 sign and bits 12:0 magnitude.
- R5: For a valid instruction, `mem_rd_en` is high for exactly one cycle with `mem_addr` equal to the effective address. `done` pulses two cycles after that read, which is four edges after start.
- R6: The modifier value 8*L + R selects bytes L..R of the memory word. These bytes are placed right-aligned in `operand`, and all bytes to their left are zero.
- R7: When L is 0, the operand's sign is the memory word's sign. When L is above 0, the operand's sign is positive.
- R8: The modifier value 5, the range (0:5), returns the whole memory word including its sign.
- R9: An effective address that is negative and non-zero, or above 3999, raises `err` and issues no read. `done` then pulses three edges after start with `operand` zero. Minus zero and 3999 are valid.
- R10: A modifier with L > R or R > 5 raises `err`, issues no read and returns a zero operand.
- R11: An index byte above 6 raises `err`, issues no read and returns a zero operand. `idx_sel` then reads 0 and `eff_addr` equals the address field.
- R12: A start asserted while an instruction is in progress is ignored. Exactly one `done` results, and it carries the first instruction's results.
- R13: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept `instr` when idle |
| instr | input | 31 | Instruction word, sign plus five bytes |
| idx_sel | output | 3 | Index register number being read |
| idx_val | input | 13 | Contents of the selected index register |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 12 | Memory read address |
| mem_rdata | input | 31 | Memory data, valid the cycle after the request |
| eff_addr | output | 14 | Effective address, sign plus 13-bit magnitude |
| operand | output | 31 | Extracted, right-aligned field |
| opcode | output | 6 | Byte 5 of the instruction |
| modifier | output | 6 | Byte 4 of the instruction |
| err | output | 1 | Address, field or index error |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the sign rules at the zero and overflow edges of the signed sum. These are a plus address cancelled by a minus index, a minus address cancelled by a plus index, and a negative address pushed positive by a larger index. The bench loads index registers with exactly those opposing magnitudes and drives matching address fields. It then checks the sign bit of `eff_addr` as well as whether a memory read happens. A second hard case is the start that arrives while the unit is busy. The stimulus holds `start` high with a different word through the index and read cycles and then confirms that only one completion appears.

// File: rtl/ofu_pkg.sv
package ofu_pkg;
    // Word geometry
    parameter int BYTE_W     = 6;
    parameter int N_BYTES    = 5;
    parameter int WORD_W     = 1 + N_BYTES * BYTE_W;
    // Address field and index registers: sign plus two bytes
    parameter int ADR_BYTES  = 2;
    parameter int ADR_MAG_W  = ADR_BYTES * BYTE_W;
    parameter int IDX_W      = 1 + ADR_MAG_W;
    parameter int IDX_COUNT  = 6;
    parameter int IDX_SEL_W  = $clog2(IDX_COUNT + 1);
    // Effective address magnitude grows by one bit through the sum
    parameter int EA_MAG_W   = ADR_MAG_W + 1;
    // Memory
    parameter int MEM_WORDS  = 4000;
    parameter int MEM_AW     = $clog2(MEM_WORDS);
    // Modifier encodes 8*L + R
    parameter int FSEL_W     = 3;

    // Byte positions inside the word (1 = most significant byte)
    parameter int POS_ADR_HI = 1;
    parameter int POS_INDEX  = 3;
    parameter int POS_MOD    = 4;
    parameter int POS_OPC    = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INDEX,
        ST_READ,
        ST_WAIT
    } ofu_state_e;

    typedef struct packed {
        ofu_state_e            state;
        logic [WORD_W-1:0]     instr;
        logic                  ea_neg;
        logic [EA_MAG_W-1:0]   ea_mag;
        logic                  err;
        logic [WORD_W-1:0]     operand;
        logic                  done;
    } ofu_regs_t;

    function automatic logic [BYTE_W-1:0] word_byte(input logic [WORD_W-1:0] w, input int pos);
        return w[(N_BYTES - pos) * BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/ofu_sm_adder.sv
module ofu_sm_adder #(
    parameter int MAG_W = 12
) (
    input  logic             a_neg,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_neg,
    input  logic [MAG_W-1:0] b_mag,
    output logic             sum_neg,
    output logic [MAG_W:0]   sum_mag
);
    logic [MAG_W:0] a_ext;
    logic [MAG_W:0] b_ext;

    assign a_ext = {1'b0, a_mag};
    assign b_ext = {1'b0, b_mag};

    always_comb begin
        if (a_neg == b_neg) begin
            sum_mag = a_ext + b_ext;
            sum_neg = a_neg;
        end else if (a_mag >= b_mag) begin
            // equal magnitudes give zero carrying the first operand's sign
            sum_mag = a_ext - b_ext;
            sum_neg = a_neg;
        end else begin
            sum_mag = b_ext - a_ext;
            sum_neg = b_neg;
        end
    end
endmodule

// File: rtl/ofu_field_extract.sv
module ofu_field_extract
    import ofu_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [FSEL_W-1:0] left_i,
    input  logic [FSEL_W-1:0] right_i,
    output logic [WORD_W-1:0] value_o,
    output logic              bad_o
);
    logic [FSEL_W-1:0] first_b;

    assign bad_o   = (left_i > right_i) || (right_i > FSEL_W'(N_BYTES));
    // the sign position never counts as a byte to move
    assign first_b = (left_i == '0) ? FSEL_W'(1) : left_i;

    assign value_o[WORD_W-1] = !bad_o && (left_i == '0) && word_i[WORD_W-1];

    for (genvar k = 1; k <= N_BYTES; k++) begin : g_out_byte
        logic [BYTE_W-1:0] pick;
        always_comb begin
            pick = '0;
            for (int j = 1; j <= N_BYTES; j++) begin
                if (!bad_o && j >= int'(first_b) && j <= int'(right_i)
                    && (j + N_BYTES - int'(right_i)) == k) begin
                    pick = word_byte(word_i, j);
                end
            end
        end
        assign value_o[(N_BYTES - k) * BYTE_W +: BYTE_W] = pick;
    end
endmodule

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit
    import ofu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WORD_W-1:0]    instr,
    output logic [IDX_SEL_W-1:0] idx_sel,
    input  logic [IDX_W-1:0]     idx_val,
    output logic                 mem_rd_en,
    output logic [MEM_AW-1:0]    mem_addr,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic [EA_MAG_W:0]    eff_addr,
    output logic [WORD_W-1:0]    operand,
    output logic [BYTE_W-1:0]    opcode,
    output logic [BYTE_W-1:0]    modifier,
    output logic                 err,
    output logic                 done
);
    ofu_regs_t q, d;

    // ---------------- decode of the latched word ----------------
    logic [BYTE_W-1:0]    idx_byte;
    logic                 idx_ok;
    logic                 idx_used;
    logic                 adr_neg;
    logic [ADR_MAG_W-1:0] adr_mag;
    logic                 add_neg;
    logic [ADR_MAG_W-1:0] add_mag;

    assign idx_byte = word_byte(q.instr, POS_INDEX);
    assign idx_ok   = idx_byte <= BYTE_W'(IDX_COUNT);
    assign idx_used = idx_ok && (idx_byte != '0);
    assign idx_sel  = idx_ok ? idx_byte[IDX_SEL_W-1:0] : '0;

    assign adr_neg  = q.instr[WORD_W-1];
    assign adr_mag  = q.instr[(N_BYTES - POS_ADR_HI - ADR_BYTES + 1) * BYTE_W +: ADR_MAG_W];
    assign add_neg  = idx_used & idx_val[IDX_W-1];
    assign add_mag  = idx_used ? idx_val[ADR_MAG_W-1:0] : '0;

    assign opcode   = word_byte(q.instr, POS_OPC);
    assign modifier = word_byte(q.instr, POS_MOD);

    // ---------------- effective address ----------------
    logic                sum_neg;
    logic [EA_MAG_W-1:0] sum_mag;
    logic                range_bad;

    ofu_sm_adder #(.MAG_W(ADR_MAG_W)) u_adder (
        .a_neg   (adr_neg),
        .a_mag   (adr_mag),
        .b_neg   (add_neg),
        .b_mag   (add_mag),
        .sum_neg (sum_neg),
        .sum_mag (sum_mag)
    );

    assign range_bad = (sum_neg && (sum_mag != '0))
                    || (sum_mag > EA_MAG_W'(MEM_WORDS - 1));

    // ---------------- field extraction ----------------
    logic [WORD_W-1:0] field_val;
    logic              field_bad;

    ofu_field_extract u_extract (
        .word_i  (mem_rdata),
        .left_i  (modifier[2*FSEL_W-1:FSEL_W]),
        .right_i (modifier[FSEL_W-1:0]),
        .value_o (field_val),
        .bad_o   (field_bad)
    );

    // ---------------- next state ----------------
    logic rd_req;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        rd_req   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.instr = instr;
                    d.state = ST_INDEX;
                end
            end
            ST_INDEX: begin
                d.ea_neg = sum_neg;
                d.ea_mag = sum_mag;
                d.err    = !idx_ok || field_bad || range_bad;
                d.state  = ST_READ;
            end
            ST_READ: begin
                if (q.err) begin
                    d.operand = '0;
                    d.done    = 1'b1;
                    d.state   = ST_IDLE;
                end else begin
                    rd_req  = 1'b1;
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                d.operand = field_val;
                d.done    = 1'b1;
                d.state   = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_rd_en = rd_req;
    assign mem_addr  = q.ea_mag[MEM_AW-1:0];
    assign eff_addr  = {q.ea_neg, q.ea_mag};
    assign operand   = q.operand;
    assign err       = q.err;
    assign done      = q.done;

    // ---------------- assertions ----------------
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R5
    rd_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 done);

    // R9
    rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ((!eff_addr[EA_MAG_W] || eff_addr[EA_MAG_W-1:0] == '0)
                       && eff_addr[EA_MAG_W-1:0] <= EA_MAG_W'(MEM_WORDS - 1)));

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (operand == '0));

    // R7
    pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && modifier[2*FSEL_W-1:FSEL_W] != '0) |-> !operand[WORD_W-1]);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(operand) && $stable(opcode) && $stable(err)));
endmodule

// File: tb/operand_fetch_unit_tb_top.sv
module operand_fetch_unit_tb_top;
    import ofu_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [WORD_W-1:0]    instr = '0;
    logic [IDX_SEL_W-1:0] idx_sel;
    logic [IDX_W-1:0]     idx_val;
    logic                 mem_rd_en;
    logic [MEM_AW-1:0]    mem_addr;
    logic [WORD_W-1:0]    mem_rdata = '0;
    logic [EA_MAG_W:0]    eff_addr;
    logic [WORD_W-1:0]    operand;
    logic [BYTE_W-1:0]    opcode;
    logic [BYTE_W-1:0]    modifier;
    logic                 err;
    logic                 done;

    always #4 clk = ~clk;   // 125 MHz

    operand_fetch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .idx_sel(idx_sel), .idx_val(idx_val),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .eff_addr(eff_addr), .operand(operand), .opcode(opcode),
        .modifier(modifier), .err(err), .done(done)
    );

    // ---------------- environment models ----------------
    logic [IDX_W-1:0] idx_regs [0:7];
    assign idx_val = idx_regs[idx_sel];

    function automatic logic [WORD_W-1:0] mem_word(input int a);
        logic [WORD_W-1:0] w;
        if (a == 31) return {1'b1, 6'd10, 6'd11, 6'd0, 6'd11, 6'd22};
        w[WORD_W-1] = a[0];
        for (int b = 1; b <= 5; b++)
            w[30 - 6*b +: 6] = 6'((a * 7 + b * 13) % 64);
        return w;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(int'(mem_addr));

    function automatic logic [WORD_W-1:0] mk(input bit neg, input int adr, input int ix,
                                             input int md, input int opc);
        return {neg, 12'(adr), 6'(ix), 6'(md), 6'(opc)};
    endfunction

    function automatic logic [WORD_W-1:0] exp_field(input logic [WORD_W-1:0] w, input int l, input int r);
        logic [WORD_W-1:0] res;
        int pos;
        res = '0;
        if (l > r || r > 5) return res;
        if (l == 0) res[30] = w[30];
        pos = 5;
        for (int j = r; j >= 1 && j >= l; j--) begin
            res[30 - 6*pos +: 6] = w[30 - 6*j +: 6];
            pos--;
        end
        return res;
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [EA_MAG_W:0]  ea;
        logic               er;
        logic [WORD_W-1:0]  v;
        logic [BYTE_W-1:0]  opc;
        logic [BYTE_W-1:0]  md;
        int                 reads;
        int                 raddr;
        string              req;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0, n_fail = 0, n_done = 0;
    int rd_cnt = 0, rd_last = -1;

    task automatic chk(input bit ok, input string req, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    always @(negedge clk) begin
        if (mem_rd_en) begin
            rd_cnt++;
            rd_last = int'(mem_addr);
        end
        if (done) begin
            n_done++;
            if (sb.size() == 0) begin
                chk(0, "R12", "done with no pending instruction (actual 1 expected 0)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(eff_addr == e.ea, e.req, $sformatf("eff_addr act %h exp %h", eff_addr, e.ea));
                chk(err == e.er, e.req, $sformatf("err act %0b exp %0b", err, e.er));
                chk(operand == e.v, e.req, $sformatf("operand act %h exp %h", operand, e.v));
                chk(opcode == e.opc && modifier == e.md, "R2",
                    $sformatf("opc/mod act %0d/%0d exp %0d/%0d", opcode, modifier, e.opc, e.md));
                chk(rd_cnt == e.reads, e.req, $sformatf("reads act %0d exp %0d", rd_cnt, e.reads));
                if (e.reads == 1)
                    chk(rd_last == e.raddr, "R5", $sformatf("rd addr act %0d exp %0d", rd_last, e.raddr));
            end
            rd_cnt = 0;
        end
    end

    function automatic exp_t predict(input logic [WORD_W-1:0] w, input string req);
        exp_t e;
        int adr, ix, add, m, l, r, mg;
        bit neg, bad;
        adr = int'(w[29:18]);
        if (w[30]) adr = -adr;
        ix  = int'(w[17:12]);
        add = 0;
        if (ix >= 1 && ix <= 6) begin
            add = int'(idx_regs[ix][11:0]);
            if (idx_regs[ix][12]) add = -add;
        end
        m   = adr + add;
        neg = (m < 0) ? 1'b1 : (m > 0) ? 1'b0 : w[30];
        mg  = (m < 0) ? -m : m;
        l   = int'(w[11:6]) / 8;
        r   = int'(w[11:6]) % 8;
        bad = (ix > 6) || (l > r) || (r > 5) || (m < 0) || (m > 3999);
        e.ea    = {neg, 13'(mg)};
        e.er    = bad;
        e.v     = bad ? '0 : exp_field(mem_word(m), l, r);
        e.opc   = w[5:0];
        e.md    = w[11:6];
        e.reads = bad ? 0 : 1;
        e.raddr = m;
        e.req   = req;
        return e;
    endfunction

    task automatic run(input logic [WORD_W-1:0] w, input string req);
        exp_t e;
        int lat;
        e = predict(w, req);
        sb.push_back(e);
        @(negedge clk);
        start = 1'b1;
        instr = w;
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (lat == 1)
                chk(idx_sel == ((w[17:12] <= 6) ? 3'(w[17:12]) : 3'd0), "R3",
                    $sformatf("idx_sel act %0d exp %0d", idx_sel, w[17:12]));
        end while (!done && lat < 20);
        chk(lat == (e.er ? 3 : 4), req, $sformatf("latency act %0d exp %0d", lat, e.er ? 3 : 4));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (actual hung, expected finish)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 8; i++) idx_regs[i] = '0;
        idx_regs[1] = {1'b1, 12'd100};
        idx_regs[2] = {1'b0, 12'd63};
        idx_regs[3] = {1'b1, 12'd5};
        idx_regs[4] = {1'b0, 12'd5};
        idx_regs[5] = {1'b0, 12'd1000};
        idx_regs[6] = {1'b0, 12'd4095};

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !err && !mem_rd_en && operand == '0, "R1",
            $sformatf("reset act done=%0b err=%0b rd=%0b v=%h exp all 0", done, err, mem_rd_en, operand));
        rst_n = 1'b1;
        @(negedge clk);

        run(mk(1, 32, 2, 11, 10), "R6");     // R3 R7: -32 + 63 = 31, field (1:3)
        run(mk(0, 31, 0, 5, 8), "R8");       // full word with its minus sign
        run(mk(0, 31, 0, 0, 1), "R7");       // (0:0) sign only
        run(mk(0, 31, 0, 45, 2), "R6");      // (5:5) last byte
        run(mk(0, 200, 0, 2, 3), "R6");      // (0:2) sign plus two bytes
        run(mk(0, 1234, 5, 28, 4), "R3");    // (3:4) with positive index add
        run(mk(0, 40, 1, 5, 5), "R9");       // 40 - 100 = -60 out of range, R4 sign
        run(mk(0, 5, 3, 5, 6), "R4");        // +5 - 5 = +0
        run(mk(1, 5, 4, 5, 7), "R4");        // -5 + 5 = -0, still valid
        run(mk(1, 100, 6, 13, 9), "R4");     // -100 + 4095 = +3995
        run(mk(0, 3999, 0, 5, 11), "R9");    // top address valid
        run(mk(0, 4000, 0, 5, 12), "R9");    // one past the end
        run(mk(0, 3500, 5, 5, 13), "R9");    // index pushes past the end
        run(mk(0, 10, 0, 26, 14), "R10");    // L=3 > R=2
        run(mk(0, 10, 0, 6, 15), "R10");     // R=6
        run(mk(0, 10, 0, 63, 16), "R10");    // L=7 R=7
        run(mk(0, 77, 7, 5, 17), "R11");     // index byte 7
        run(mk(1, 77, 40, 5, 18), "R11");    // index byte 40

        // R2: outputs hold after completion
        begin
            logic [WORD_W-1:0] v0;
            logic [EA_MAG_W:0] ea0;
            v0 = operand;
            ea0 = eff_addr;
            repeat (4) @(negedge clk);
            chk(operand == v0 && eff_addr == ea0 && opcode == 6'd18 && err, "R2",
                $sformatf("hold act v=%h ea=%h opc=%0d exp v=%h ea=%h opc=18", operand, eff_addr, opcode, v0, ea0));
        end

        // R12: start while busy is ignored
        begin
            int d0;
            d0 = n_done;
            sb.push_back(predict(mk(0, 31, 2, 21, 19), "R12"));   // 31+63=94, (2:5)
            @(negedge clk);
            start = 1'b1;
            instr = mk(0, 31, 2, 21, 19);
            @(negedge clk);
            instr = mk(0, 900, 0, 5, 20);
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
            repeat (8) @(negedge clk);
            chk(n_done == d0 + 1, "R12", $sformatf("done count act %0d exp %0d", n_done - d0, 1));
        end

        // R13: done never lasts two sampled cycles
        begin
            int hi;
            hi = 0;
            sb.push_back(predict(mk(0, 300, 0, 5, 21), "R13"));
            @(negedge clk);
            start = 1'b1;
            instr = mk(0, 300, 0, 5, 21);
            @(negedge clk);
            start = 1'b0;
            repeat (6) begin
                @(negedge clk);
                if (done) hi++;
            end
            chk(hi == 1, "R13", $sformatf("done cycles act %0d exp 1", hi));
        end

        chk(sb.size() == 0, "R5", $sformatf("pending act %0d exp 0", sb.size()));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule